// File: doc/BRIEF.md
# Banked I/O Strobe and Wait-State Controller

This block stands between a processor's I/O bus cycle and the peripherals hung off that bus. The 16-bit I/O address space is cut into eight equal banks of 8 KB, chosen by the top three address bits. Each bank has a small control register. The register sets how many wait states stretch an external access to that bank, whether writes into the bank are inhibited, and what kind of active-low strobe the bank's output pin carries.

A bus cycle begins with a one-clock start pulse that carries the address, the direction and an internal/external flag. The block holds `busy` for the rest of the cycle and raises `cyc_done` in the cycle's last clock. While busy, it drives the global read and write strobes and the selected bank's pin.

Internal I/O cycles always take two clocks and produce no strobes. External cycles take two clocks plus the programmed wait states. A bank pin only becomes active when its direction bit and its function bit are both set. The wait states still apply when the pin is held off.

Top module: `io_bank_ctrl`

## Requirements
- R1: The bank of a cycle is `cyc_addr[15:13]`; only the pin of that bank (`bank_strobe_n[bank]`) can go low during the cycle.
- R2: Bank register field bits [4:3] of the written image (byte bits 7:6) hold the wait code: 00 gives 15, 01 gives 7, 10 gives 3 and 11 gives 1 wait state. An external cycle lasts 2 + waits clocks, counting the start clock, with `cyc_done` high in the last one only.
- R3: A synchronous reset clears every bank register, so each bank has 15 waits, chip-select kind and no inhibit. Reset also leaves `busy` and `cyc_done` low and all strobes high.
- R4: An internal cycle lasts exactly two clocks whatever the bank registers hold, and asserts no strobe.
- R5: During an external cycle, `io_rd_n` is low for a read and `io_wr_n` is low for a write. Each is low from the clock after the start clock through the clock in which `cyc_done` is high.
- R6: Byte bits 4:3 select the pin kind. 00 is chip select (low for reads and writes), 01 is a read strobe, 10 is a write strobe, and 11 is a read-or-write strobe.
- R7: Byte bit 5 is write-inhibit. When it is set, writes to the bank leave `io_wr_n` high and suppress the pin for the write and read-or-write kinds. Chip select and reads are unaffected.
- R8: A bank pin goes low only if `port_dir[bank]` and `port_fn[bank]` are both 1. The cycle length does not depend on either bit.
- R9: A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bank register write enable |
| cfg_sel | input | 3 | Bank register index |
| cfg_wdata | input | 8 | Register byte; bits 2:0 are not stored |
| cyc_start | input | 1 | One-clock start of an I/O bus cycle |
| cyc_addr | input | 16 | I/O address of the cycle |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read |
| cyc_internal | input | 1 | 1 for an internal I/O cycle |
| port_dir | input | 8 | Per-pin output direction enables |
| port_fn | input | 8 | Per-pin strobe function selects |
| busy | output | 1 | Cycle in progress after its start clock |
| cyc_done | output | 1 | High in the last clock of a cycle |
| io_rd_n | output | 1 | Global read strobe, active low |
| io_wr_n | output | 1 | Global write strobe, active low |
| bank_strobe_n | output | 8 | Per-bank strobe pins, active low |

## Verification
The test sweeps all four wait codes across all eight banks. This shows that the length of each cycle follows its own bank's register and the correct address slice, and not a neighbour's. Each pin kind is run with both reads and writes, with and without inhibit, which separates the kinds from one another and the inhibit from the plain write strobe. Separate runs then cover three cases: direction or function bit alone (the pin stays off while the timing is unchanged), an internal access to a bank set to its slowest code, and a second start pulse in the middle of a cycle.

// File: rtl/io_bank_pkg.sv
package io_bank_pkg;

    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        KIND_CS  = 2'b00,
        KIND_RD  = 2'b01,
        KIND_WR  = 2'b10,
        KIND_RW  = 2'b11
    } pin_kind_e;

    // stored image of register byte bits 7:3
    typedef struct packed {
        logic [1:0] wcode;
        logic       wr_block;
        pin_kind_e  kind;
    } bank_cfg_t;

    localparam int CFG_BITS = $bits(bank_cfg_t);

    // code 0 -> 15, 1 -> 7, 2 -> 3, 3 -> 1
    function automatic logic [WAIT_W-1:0] wait_count(input logic [1:0] code);
        logic [WAIT_W:0] span;
        span = (WAIT_W+1)'(1) << (3'(WAIT_W) - {1'b0, code});
        return WAIT_W'(span - (WAIT_W+1)'(1));
    endfunction

    function automatic logic kind_fires(input pin_kind_e k, input logic wr, input logic blk);
        case (k)
            KIND_CS: return 1'b1;
            KIND_RD: return !wr;
            KIND_WR: return wr && !blk;
            default: return !wr || !blk;
        endcase
    endfunction

endpackage

// File: rtl/io_bank_regs.sv
module io_bank_regs
    import io_bank_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SEL_W-1:0]       sel,
    input  logic [BYTE_W-1:0]      wdata,
    output bank_cfg_t [NBANK-1:0]  cfg_q
);
    logic unused_low_bits;
    assign unused_low_bits = ^wdata[BYTE_W-CFG_BITS-1:0];

    for (genvar i = 0; i < NBANK; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                cfg_q[i] <= bank_cfg_t'(wdata[BYTE_W-1 -: CFG_BITS]);
            end
        end
    end
endmodule

// File: rtl/io_bank_timer.sv
module io_bank_timer
    import io_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              active,
    output logic              done
);
    logic [WAIT_W-1:0] cnt;

    assign done = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= load_val;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/io_bank_strobe.sv
module io_bank_strobe
    import io_bank_pkg::*;
#(
    parameter int NBANK = 8,
    localparam int SEL_W = $clog2(NBANK)
) (
    input  logic                  active,
    input  logic                  write,
    input  logic                  internal,
    input  logic [SEL_W-1:0]      bank,
    input  bank_cfg_t [NBANK-1:0] cfg,
    input  logic [NBANK-1:0]      port_dir,
    input  logic [NBANK-1:0]      port_fn,
    output logic                  rd_n,
    output logic                  wr_n,
    output logic [NBANK-1:0]      pins_n
);
    logic ext;
    assign ext  = active && !internal;
    assign rd_n = !(ext && !write);
    assign wr_n = !(ext && write && !cfg[bank].wr_block);

    for (genvar i = 0; i < NBANK; i++) begin : g_pin
        logic fire;
        assign fire = ext && (bank == SEL_W'(i))
                   && kind_fires(cfg[i].kind, write, cfg[i].wr_block);
        assign pins_n[i] = !(fire && port_dir[i] && port_fn[i]);
    end
endmodule

// File: rtl/io_bank_ctrl.sv
module io_bank_ctrl
    import io_bank_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic              cyc_internal,
    input  logic [NBANK-1:0]  port_dir,
    input  logic [NBANK-1:0]  port_fn,
    output logic              busy,
    output logic              cyc_done,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [NBANK-1:0]  bank_strobe_n
);
    bank_cfg_t [NBANK-1:0] cfg;
    logic [SEL_W-1:0]      in_bank, cur_bank;
    logic                  cur_write, cur_internal, load;
    logic [WAIT_W-1:0]     load_val;
    logic                  unused_addr_bits;

    assign in_bank          = cyc_addr[ADDR_W-1 -: SEL_W];
    assign unused_addr_bits = ^cyc_addr[ADDR_W-SEL_W-1:0];
    assign load             = cyc_start && !busy;
    assign load_val         = cyc_internal ? '0 : wait_count(cfg[in_bank].wcode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bank     <= '0;
            cur_write    <= 1'b0;
            cur_internal <= 1'b0;
        end else if (load) begin
            cur_bank     <= in_bank;
            cur_write    <= cyc_write;
            cur_internal <= cyc_internal;
        end
    end

    io_bank_regs #(.NBANK(NBANK), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .cfg_q(cfg)
    );

    io_bank_timer u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .active(busy), .done(cyc_done)
    );

    io_bank_strobe #(.NBANK(NBANK)) u_strobe (
        .active(busy), .write(cur_write), .internal(cur_internal),
        .bank(cur_bank), .cfg(cfg), .port_dir(port_dir), .port_fn(port_fn),
        .rd_n(io_rd_n), .wr_n(io_wr_n), .pins_n(bank_strobe_n)
    );
endmodule

// File: rtl/io_bank_ctrl_chk.sv
module io_bank_ctrl_chk #(
    parameter int NBANK = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_start,
    input logic             cyc_internal,
    input logic             busy,
    input logic             cyc_done,
    input logic             io_rd_n,
    input logic             io_wr_n,
    input logic [NBANK-1:0] bank_strobe_n,
    input logic [NBANK-1:0] port_dir,
    input logic [NBANK-1:0] port_fn
);
    // R3: the clock after reset is idle
    a_r3_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !cyc_done && io_rd_n && io_wr_n && (&bank_strobe_n)));

    // R1: at most one bank pin low at a time
    a_r1_one_pin: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bank_strobe_n));

    // R2: done lasts one clock and ends the cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);

    // R2: an accepted external start is never done in the next clock
    a_r2_min_wait: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !cyc_internal && !busy) |=> (busy && !cyc_done));

    // R4: an accepted internal start finishes in the next clock without strobes
    a_r4_internal_short: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_internal && !busy) |=>
            (cyc_done && io_rd_n && io_wr_n && (&bank_strobe_n)));

    // R5: strobes only inside a cycle and never both
    a_r5_strobe_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (!io_rd_n || !io_wr_n) |-> (busy && (io_rd_n || io_wr_n)));

    // R8: a pin without both enables stays high
    a_r8_pin_gate: assert property (@(posedge clk) disable iff (rst)
        ((~bank_strobe_n) & ~(port_dir & port_fn)) == '0);

    // R9: an unfinished cycle keeps busy
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !cyc_done) |=> busy);
endmodule

bind io_bank_ctrl io_bank_ctrl_chk #(.NBANK(NBANK)) u_chk (.*);

// File: tb/io_bank_ctrl_test.sv
module io_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       cyc_start, cyc_write, cyc_internal;
    logic [15:0] cyc_addr;
    logic [7:0] port_dir, port_fn;
    logic       busy, cyc_done, io_rd_n, io_wr_n;
    logic [7:0] bank_strobe_n;

    int errors = 0;
    int checks = 0;

    // shadow of written registers
    int sh_code [8];
    int sh_kind [8];
    bit sh_inh  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    io_bank_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .cyc_internal(cyc_internal),
        .port_dir(port_dir), .port_fn(port_fn), .busy(busy),
        .cyc_done(cyc_done), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .bank_strobe_n(bank_strobe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int waits_of(input int code);
        case (code)
            0: return 15;
            1: return 7;
            2: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic bit fires(input int kind, input bit wr, input bit inh);
        case (kind)
            0: return 1'b1;
            1: return !wr;
            2: return wr && !inh;
            default: return !wr || !inh;
        endcase
    endfunction

    task automatic set_bank(input int b, input int code, input bit inh, input int kind);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'(b);
        cfg_wdata = {2'(code), inh, 2'(kind), 3'b101};
        @(negedge clk);
        cfg_we    = 1'b0;
        sh_code[b] = code;
        sh_inh[b]  = inh;
        sh_kind[b] = kind;
    endtask

    task automatic do_cycle(input logic [15:0] a, input bit wr, input bit intl, input string req);
        int b, len, exp_len;
        logic [7:0] exp_pins;
        b = int'(a[15:13]);
        exp_len  = intl ? 2 : 2 + waits_of(sh_code[b]);
        exp_pins = 8'hFF;
        if (!intl && fires(sh_kind[b], wr, sh_inh[b]) && port_dir[b] && port_fn[b])
            exp_pins[b] = 1'b0;
        @(negedge clk);
        cyc_addr = a; cyc_write = wr; cyc_internal = intl; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        len = 2;
        chk(bank_strobe_n == exp_pins, {req, " pins"}, int'(bank_strobe_n), int'(exp_pins));
        chk(io_rd_n == !(!intl && !wr), {req, " rd_n"}, int'(io_rd_n), int'(!(!intl && !wr)));
        chk(io_wr_n == !(!intl && wr && !sh_inh[b]), {req, " wr_n"},
            int'(io_wr_n), int'(!(!intl && wr && !sh_inh[b])));
        while (!cyc_done && len < 40) begin
            @(negedge clk);
            len++;
        end
        chk(len == exp_len, {req, " length"}, len, exp_len);
        @(negedge clk);
        chk(!busy && bank_strobe_n == 8'hFF && io_rd_n && io_wr_n, {req, " idle after"},
            int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !cyc_done, "R3 busy/done", int'(busy) + int'(cyc_done), 0);
        chk(io_rd_n && io_wr_n && bank_strobe_n == 8'hFF, "R3 strobes",
            int'(bank_strobe_n), 255);
        // defaults: 15 waits, chip select
        do_cycle(16'h6123, 1'b0, 1'b0, "R3 default read");
        do_cycle(16'h6000, 1'b1, 1'b0, "R3 default write");
    endtask

    task automatic t_codes();
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < 4; c++) begin
                set_bank(b, c, 1'b0, 0);
                do_cycle({3'(b), 13'h0A5A}, c[0], 1'b0, "R2 R1 code sweep");
            end
        end
    endtask

    task automatic t_kinds();
        for (int k = 0; k < 4; k++) begin
            set_bank(5, 3, 1'b0, k);
            do_cycle(16'hA010, 1'b0, 1'b0, "R6 R5 kind read");
            do_cycle(16'hBFFF, 1'b1, 1'b0, "R6 R5 kind write");
        end
    endtask

    task automatic t_inhibit();
        for (int k = 0; k < 4; k++) begin
            set_bank(2, 2, 1'b1, k);
            do_cycle(16'h4001, 1'b1, 1'b0, "R7 inhibited write");
            do_cycle(16'h5FFE, 1'b0, 1'b0, "R7 read under inhibit");
        end
    endtask

    task automatic t_gating();
        set_bank(6, 2, 1'b0, 0);
        port_dir = 8'hFF; port_fn = 8'hBF;
        do_cycle(16'hC000, 1'b0, 1'b0, "R8 function bit clear");
        port_dir = 8'hBF; port_fn = 8'hFF;
        do_cycle(16'hC000, 1'b1, 1'b0, "R8 direction bit clear");
        port_dir = 8'hFF; port_fn = 8'hFF;
        do_cycle(16'hC000, 1'b1, 1'b0, "R8 both set");
    endtask

    task automatic t_internal();
        set_bank(7, 0, 1'b0, 3);
        do_cycle(16'hE000, 1'b0, 1'b1, "R4 internal read");
        do_cycle(16'hFFFF, 1'b1, 1'b1, "R4 internal write");
    endtask

    task automatic t_busy_start();
        set_bank(1, 3, 1'b0, 0);
        @(negedge clk);
        cyc_addr = 16'h2000; cyc_write = 1'b0; cyc_internal = 1'b0; cyc_start = 1'b1;
        @(negedge clk);
        cyc_addr = 16'h0000; cyc_internal = 1'b1;  // second start while busy
        chk(busy && !cyc_done, "R9 clock 2", int'(cyc_done), 0);
        @(negedge clk);
        cyc_start = 1'b0; cyc_internal = 1'b0;
        chk(cyc_done && bank_strobe_n == 8'hFD, "R9 first cycle kept",
            int'(bank_strobe_n), 253);
        @(negedge clk);
        chk(!busy && !cyc_done, "R9 second start dropped", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            sh_code[i] = 0; sh_kind[i] = 0; sh_inh[i] = 1'b0;
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        cyc_start = 1'b0; cyc_addr = '0; cyc_write = 1'b0; cyc_internal = 1'b0;
        port_dir = 8'hFF; port_fn = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_kinds();
        t_inhibit();
        t_gating();
        t_internal();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule